// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is an on-chip scratchpad split into several equally sized single-ported banks, shared by a group of lanes that run in lock step. A request carries one address, one data word and one active bit per lane, plus a single write/read flag for the whole vector. The low bits of each word address select a bank and the remaining bits select a row inside it. Because every bank has only one port, lanes that reach different words of the same bank must be served in separate passes. The block finds these collisions and serializes them into the fewest passes that are free of conflicts. A word read by several lanes is fetched once and handed to all of them.

The lane group is handled as consecutive sub-groups, each as wide as the bank count, taken in order. While the vector is in progress the block is busy and refuses new requests through a valid/ready handshake. When the last pass completes, the block pulses a done flag. At that moment it presents the read data of every lane and the number of passes the request cost, which is its conflict degree.

Top module: `banked_scratchpad`

## Requirements
- R1: A lane's word address selects bank `addr % BANKS` (the low address bits) and row `addr / BANKS`. A word written at an address is returned by a later read of that address.
- R2: The reported degree is the sum, over sub-groups, of the largest number of distinct words that active lanes of that sub-group request from any one bank. A sub-group whose lanes all reach distinct banks therefore adds exactly 1.
- R3: The request keeps `busy` high for a number of cycles equal to the sum, over sub-groups, of max(1, that sub-group's degree contribution).
- R4: Several lanes reading the same word cost no extra pass, and each of those lanes receives the word.
- R5: Lanes are split into LANES/BANKS sub-groups of BANKS consecutive lanes, starting with lane 0. The sub-groups are serviced in ascending order.
- R6: When several active lanes write the same word in one request, the data of the highest-numbered of those lanes is what remains stored.
- R7: A request is taken only on a cycle with `req_valid` and `req_ready` both high. `req_ready` is low and `busy` is high from the cycle after acceptance until the done pulse. Inputs presented while busy have no effect.
- R8: `resp_done` is a one-cycle pulse after the final pass. With it, `resp_rdata` and `resp_degree` hold the result, and they stay stable until the next acceptance.
- R9: Inactive lanes add nothing to the degree and return zero read data. A write request returns zero read data on every lane.
- R10: After reset the block is ready, not busy, with no done pulse, zero degree and zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_lane_valid | input | LANES | Per-lane active bits |
| req_we | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | LANES*AW | Per-lane word addresses, lane 0 in the low bits |
| req_wdata | input | LANES*DW | Per-lane write data, lane 0 in the low bits |
| busy | output | 1 | Request in progress |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_rdata | output | LANES*DW | Per-lane read data, lane 0 in the low bits |
| resp_degree | output | DGW | Passes used by the last request |

## Verification
The bench targets several corner cases, each of which shows a specific fault when handled wrongly:
- **Same-bank strides.** Stride-4 addressing puts every lane in one bank. A design that fails to serialize these accesses would return one lane's word to all lanes or report too few passes. A stride-2 pattern, which should give a two-way conflict, is also exercised.
- **Broadcast.** All lanes read a single word. A design that treats this as a conflict would report eight passes instead of two.
- **Write races.** Races inside one sub-group and across sub-groups show whether lane priority is reversed.
- **Inactive lanes.** Sparse or empty lane masks catch lanes that leak stale data or inflate the degree.
- **Busy-period inputs.** New inputs offered while busy catch a block that takes a second request mid-flight.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
   // Width of an index able to count 0..v-1, never below one bit.
   function automatic int idx_w(input int v);
      return (v > 1) ? $clog2(v) : 1;
   endfunction
endpackage

// File: rtl/bsp_bank.sv
module bsp_bank #(
   parameter int DEPTH = 16,
   parameter int DW    = 32,
   localparam int RW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [RW-1:0] row,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[row] <= wdata;
   end

   assign rdata = mem[row];
endmodule

// File: rtl/bsp_arbiter.sv
// One pass of one sub-group: every bank picks the word of its lowest pending
// lane; all pending lanes on that word are served; on writes the highest
// served lane supplies the data.
module bsp_arbiter #(
   parameter int BANKS = 32,
   parameter int AW    = 9,
   parameter int DW    = 32,
   localparam int BW   = $clog2(BANKS),
   localparam int RW   = AW - BW
) (
   input  logic [BANKS-1:0]    pend,
   input  logic [BANKS*AW-1:0] addr,
   input  logic [BANKS*DW-1:0] wdata,
   output logic [BANKS-1:0]    bk_en,
   output logic [BANKS*RW-1:0] bk_row,
   output logic [BANKS*DW-1:0] bk_wdata,
   output logic [BANKS-1:0]    served
);
   logic [AW-1:0] a   [BANKS];
   logic [DW-1:0] d   [BANKS];
   logic [AW-1:0] sel [BANKS];
   logic [DW-1:0] wd;

   always_comb begin
      for (int j = 0; j < BANKS; j++) begin
         a[j] = addr[j*AW +: AW];
         d[j] = wdata[j*DW +: DW];
      end
      for (int b = 0; b < BANKS; b++) begin
         sel[b]   = '0;
         bk_en[b] = 1'b0;
         for (int j = BANKS-1; j >= 0; j--) begin
            if (pend[j] && a[j][BW-1:0] == BW'(b)) begin
               sel[b]   = a[j];
               bk_en[b] = 1'b1;
            end
         end
      end
      for (int j = 0; j < BANKS; j++) begin
         served[j] = pend[j] && (a[j] == sel[a[j][BW-1:0]]);
      end
      for (int b = 0; b < BANKS; b++) begin
         wd = '0;
         for (int j = 0; j < BANKS; j++) begin
            if (served[j] && a[j][BW-1:0] == BW'(b)) wd = d[j];
         end
         bk_wdata[b*DW +: DW] = wd;
         bk_row[b*RW +: RW]   = sel[b][AW-1:BW];
      end
   end
endmodule

// File: rtl/banked_scratchpad.sv
module banked_scratchpad #(
   parameter int BANKS = 32,
   parameter int LANES = 32,
   parameter int DEPTH = 16,
   parameter int DW    = 32,
   localparam int BW   = $clog2(BANKS),
   localparam int RW   = $clog2(DEPTH),
   localparam int AW   = BW + RW,
   localparam int NGRP = LANES / BANKS,
   localparam int GW   = bsp_pkg::idx_w(NGRP),
   localparam int DGW  = $clog2(LANES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [LANES-1:0]    req_lane_valid,
   input  logic                req_we,
   input  logic [LANES*AW-1:0] req_addr,
   input  logic [LANES*DW-1:0] req_wdata,
   output logic                busy,
   output logic                resp_done,
   output logic [LANES*DW-1:0] resp_rdata,
   output logic [DGW-1:0]      resp_degree
);
   if (BANKS < 2 || (1 << BW) != BANKS) begin : g_bad_banks
      $error("BANKS must be a power of two of at least 2");
   end
   if (DEPTH < 2 || (1 << RW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (LANES < BANKS || (LANES % BANKS) != 0) begin : g_bad_lanes
      $error("LANES must be a nonzero multiple of BANKS");
   end

   logic                busy_q, we_q, done_q;
   logic [GW-1:0]       grp_q;
   logic [LANES-1:0]    pend_q;
   logic [LANES*AW-1:0] addr_q;
   logic [LANES*DW-1:0] wdata_q, rdata_q;
   logic [DGW-1:0]      degree_q;

   int                  grp_off;
   logic [BANKS-1:0]    g_pend, served, bk_en, g_left;
   logic [BANKS*AW-1:0] g_addr;
   logic [BANKS*DW-1:0] g_wdata, bk_wdata;
   logic [BANKS*RW-1:0] bk_row;
   logic [DW-1:0]       bank_rd [BANKS];
   logic [DW-1:0]       lane_rd [BANKS];
   logic [BW-1:0]       lane_bk [BANKS];

   always_comb begin
      grp_off = int'(grp_q) * BANKS;
      g_pend  = pend_q[grp_off +: BANKS];
      g_addr  = addr_q[grp_off*AW +: BANKS*AW];
      g_wdata = wdata_q[grp_off*DW +: BANKS*DW];
      g_left  = g_pend & ~served;
      for (int j = 0; j < BANKS; j++) begin
         lane_bk[j] = g_addr[j*AW +: BW];
         lane_rd[j] = bank_rd[lane_bk[j]];
      end
   end

   bsp_arbiter #(.BANKS(BANKS), .AW(AW), .DW(DW)) u_arb (
      .pend(g_pend), .addr(g_addr), .wdata(g_wdata),
      .bk_en(bk_en), .bk_row(bk_row), .bk_wdata(bk_wdata), .served(served)
   );

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      bsp_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
         .clk  (clk),
         .wr_en(busy_q && we_q && bk_en[b]),
         .row  (bk_row[b*RW +: RW]),
         .wdata(bk_wdata[b*DW +: DW]),
         .rdata(bank_rd[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         we_q     <= 1'b0;
         done_q   <= 1'b0;
         grp_q    <= '0;
         pend_q   <= '0;
         addr_q   <= '0;
         wdata_q  <= '0;
         rdata_q  <= '0;
         degree_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (req_valid) begin
               busy_q   <= 1'b1;
               grp_q    <= '0;
               pend_q   <= req_lane_valid;
               addr_q   <= req_addr;
               wdata_q  <= req_wdata;
               we_q     <= req_we;
               rdata_q  <= '0;
               degree_q <= '0;
            end
         end else begin
            pend_q[grp_off +: BANKS] <= g_left;
            if (|g_pend) degree_q <= degree_q + 1'b1;
            if (!we_q) begin
               for (int j = 0; j < BANKS; j++) begin
                  if (served[j]) rdata_q[(grp_off+j)*DW +: DW] <= lane_rd[j];
               end
            end
            if (g_left == '0) begin
               if (grp_q == GW'(NGRP-1)) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  grp_q <= grp_q + 1'b1;
               end
            end
         end
      end
   end

   assign req_ready   = !busy_q;
   assign busy        = busy_q;
   assign resp_done   = done_q;
   assign resp_rdata  = rdata_q;
   assign resp_degree = degree_q;
endmodule

// File: rtl/bsp_chk.sv
module bsp_chk #(
   parameter int LANES = 32,
   parameter int DW    = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_ready,
   input logic [LANES-1:0]    req_lane_valid,
   input logic                req_we,
   input logic                busy,
   input logic                resp_done,
   input logic [LANES*DW-1:0] resp_rdata
);
   logic [LANES-1:0] live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      live_q <= '0;
      else if (req_valid && req_ready) live_q <= req_we ? '0 : req_lane_valid;
   end

   // R7
   accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> busy);
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_done |=> !resp_done);
   // R8
   done_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_done |-> (!busy && req_ready));
   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !req_valid) |=> $stable(resp_rdata));

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      // R9
      idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (resp_done && !live_q[l]) |-> (resp_rdata[l*DW +: DW] == '0));
   end
endmodule

bind banked_scratchpad bsp_chk #(.LANES(LANES), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_lane_valid(req_lane_valid), .req_we(req_we), .busy(busy),
   .resp_done(resp_done), .resp_rdata(resp_rdata)
);

// File: tb/banked_scratchpad_tb.sv
module banked_scratchpad_tb;
   localparam int CLK_PERIOD = 10;
   localparam int BANKS = 4;
   localparam int LANES = 8;
   localparam int DEPTH = 4;
   localparam int DW    = 16;
   localparam int AW    = 4;
   localparam int DGW   = 4;
   localparam int WORDS = BANKS * DEPTH;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                req_valid = 1'b0;
   logic                req_ready;
   logic [LANES-1:0]    req_lane_valid = '0;
   logic                req_we = 1'b0;
   logic [LANES*AW-1:0] req_addr = '0;
   logic [LANES*DW-1:0] req_wdata = '0;
   logic                busy, resp_done;
   logic [LANES*DW-1:0] resp_rdata;
   logic [DGW-1:0]      resp_degree;

   int n_chk = 0, n_fail = 0;
   logic [DW-1:0] model [WORDS];
   logic [AW-1:0] ta [LANES];
   logic [DW-1:0] td [LANES];

   always #(CLK_PERIOD/2) clk = ~clk;

   banked_scratchpad #(.BANKS(BANKS), .LANES(LANES), .DEPTH(DEPTH), .DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_lane_valid(req_lane_valid), .req_we(req_we), .req_addr(req_addr),
      .req_wdata(req_wdata), .busy(busy), .resp_done(resp_done),
      .resp_rdata(resp_rdata), .resp_degree(resp_degree)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Expected pass counts from the requirements (R2, R3, R5).
   function automatic void expect_passes(input logic [LANES-1:0] m, output int deg, output int cyc);
      deg = 0; cyc = 0;
      for (int g = 0; g < LANES/BANKS; g++) begin
         int gmax = 0;
         for (int b = 0; b < BANKS; b++) begin
            int cnt = 0;
            for (int j = 0; j < BANKS; j++) begin
               int l = g*BANKS + j;
               bit fresh = m[l] && (ta[l] % BANKS == b);
               for (int i = 0; i < j; i++)
                  if (m[g*BANKS+i] && ta[g*BANKS+i] == ta[l]) fresh = 0;
               if (fresh) cnt++;
            end
            if (cnt > gmax) gmax = cnt;
         end
         deg += gmax;
         cyc += (gmax > 0) ? gmax : 1;
      end
   endfunction

   task automatic run_req(input logic [LANES-1:0] m, input bit we, input string tag,
                          input bit junk_while_busy);
      int edeg, ecyc, cyc;
      logic [DW-1:0] exp_rd [LANES];
      expect_passes(m, edeg, ecyc);
      for (int l = 0; l < LANES; l++)
         exp_rd[l] = (!we && m[l]) ? model[ta[l]] : '0;
      @(negedge clk);
      req_valid = 1'b1; req_lane_valid = m; req_we = we;
      for (int l = 0; l < LANES; l++) begin
         req_addr[l*AW +: AW]  = ta[l];
         req_wdata[l*DW +: DW] = td[l];
      end
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 0;
      while (!resp_done && cyc < 200) begin
         if (junk_while_busy && cyc < 2) begin
            // R7: offered while busy, must be ignored
            req_valid = 1'b1; req_we = 1'b1; req_lane_valid = '1;
            req_addr = '0; req_wdata = '1;
            check(req_ready == 1'b0 && busy == 1'b1, "R7 ready low while busy", req_ready, 0);
         end else begin
            req_valid = 1'b0;
         end
         if (busy) cyc++;
         @(negedge clk);
      end
      req_valid = 1'b0;
      check(resp_done == 1'b1, {tag, " R8 done pulse"}, resp_done, 1);
      check(resp_degree == DGW'(edeg), {tag, " R2 degree"}, resp_degree, edeg);
      check(cyc == ecyc, {tag, " R3 busy cycles"}, cyc, ecyc);
      for (int l = 0; l < LANES; l++)
         check(resp_rdata[l*DW +: DW] == exp_rd[l], {tag, " R1/R9 lane data"},
               resp_rdata[l*DW +: DW], exp_rd[l]);
      if (we)
         for (int l = 0; l < LANES; l++) if (m[l]) model[ta[l]] = td[l]; // R6: higher lane last
      @(negedge clk);
      check(resp_done == 1'b0 && req_ready == 1'b1, {tag, " R8 single pulse"}, resp_done, 0);
   endtask

   task automatic t_reset;
      check(req_ready == 1'b1 && busy == 1'b0, "R10 ready after reset", busy, 0);
      check(resp_done == 1'b0 && resp_degree == '0, "R10 no done, zero degree", resp_degree, 0);
      check(resp_rdata == '0, "R10 zero data", 0, 0);
   endtask

   task automatic t_fill;   // R1, R5: two write vectors covering every word
      for (int p = 0; p < 2; p++) begin
         for (int l = 0; l < LANES; l++) begin
            ta[l] = AW'(p*LANES + l); td[l] = DW'(16'hA000 + p*LANES + l);
         end
         run_req('1, 1'b1, "R1 fill", 1'b0);
      end
   endtask

   task automatic t_unit_stride;   // R1, R2
      for (int l = 0; l < LANES; l++) ta[l] = AW'(l + 3);
      run_req('1, 1'b0, "R1 unit stride read", 1'b0);
   endtask

   task automatic t_stride2;   // R2, R3: two-way conflict per sub-group
      for (int l = 0; l < LANES; l++) ta[l] = AW'(2*l);
      run_req('1, 1'b0, "R3 stride two", 1'b0);
   endtask

   task automatic t_same_bank;   // R3, R5: every lane in bank 1
      for (int l = 0; l < LANES; l++) ta[l] = AW'(4*(l % 4) + 1);
      run_req('1, 1'b0, "R3 same bank", 1'b0);
   endtask

   task automatic t_broadcast;   // R4
      for (int l = 0; l < LANES; l++) ta[l] = AW'(5);
      run_req('1, 1'b0, "R4 broadcast", 1'b0);
   endtask

   task automatic t_sparse;   // R9
      for (int l = 0; l < LANES; l++) ta[l] = AW'(1);
      run_req(8'b0001_0001, 1'b0, "R9 sparse", 1'b0);
      run_req(8'b0000_0000, 1'b0, "R9 empty", 1'b0);
   endtask

   task automatic t_race;   // R6
      for (int l = 0; l < LANES; l++) begin ta[l] = AW'(9); td[l] = DW'(16'hB000 + l); end
      run_req(8'b0000_1111, 1'b1, "R6 race in group", 1'b0);
      run_req(8'b0000_0001, 1'b0, "R6 readback in group", 1'b0);
      for (int l = 0; l < LANES; l++) begin ta[l] = AW'(3); td[l] = DW'(16'hC000 + l); end
      run_req('1, 1'b1, "R6 race across groups", 1'b0);
      run_req('1, 1'b0, "R6 readback across groups", 1'b0);
      check(resp_rdata[0 +: DW] == 16'hC007, "R6 highest lane wins", resp_rdata[0 +: DW], 16'hC007);
   endtask

   task automatic t_held_off;   // R7: junk offered during busy must not land
      for (int l = 0; l < LANES; l++) ta[l] = AW'(4*(l % 4) + 2);
      run_req('1, 1'b0, "R7 held off", 1'b1);
      for (int l = 0; l < LANES; l++) ta[l] = AW'(l);
      run_req('1, 1'b0, "R7 memory untouched", 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD*20000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fill();
      t_unit_stride();
      t_stride2();
      t_same_bank();
      t_broadcast();
      t_sparse();
      t_race();
      t_held_off();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule